// File: doc/BRIEF.md
# Core Clock Ratio Controller

This block works out the core, system-bus and memory-controller clock frequencies from two software-written words. The first word is a staged ratio register: a run multiplier applied to the 13 MHz crystal, a turbo field that holds twice the turbo ratio, and a memory-clock select bit. The second word holds the clock mode: fast bus, turbo, half turbo, a bypass bit that runs the whole clock tree directly from the crystal, and a change bit that starts a frequency change. Each output frequency is given as a code equal to its value in whole MHz. A PLL model or clock generator downstream uses these codes.

A mode write without the change bit takes effect at once, because it needs no PLL restart. A mode write with the change bit runs an automatic sequence. The PLL is stopped, then restarted, and the block then waits for lock or for a programmable timeout. At the end of the wait the staged ratios are committed. A start pulse at the beginning of the sequence lets a neighbouring voltage sequencer couple its own change to the frequency change. A second change request during a sequence is dropped and flagged.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset the committed point is run multiplier 7 and turbo field 2, with memory select clear and all mode bits clear. The outputs are core 91, bus 45 and memory 91, and point_boot is 1. busy, fc_start, pll_stop, pll_restart, lock_wait and req_dropped are all 0.
- R2: With turbo, half turbo and bypass all clear, the core code equals 13 times the committed run multiplier L.
- R3: With turbo set and half turbo and bypass clear, the core code equals floor(13*L*N2/2), where N2 is the committed turbo field.
- R4: With half turbo set and bypass clear, the core code equals floor(13*L*N2/4), whatever the turbo bit is.
- R5: With bypass clear, the bus code equals 13*L when fast bus is set and floor(13*L/2) when it is clear.
- R6: With bypass clear, the memory code equals the bus code when memory select is set. When memory select is clear, the memory code is 13*L for L up to 10 and floor(13*L/2) above 10.
- R7: With bypass set, all three codes equal 13, whatever the other bits and ratios are.
- R8: A ratio write never changes the outputs by itself. The new ratios act only when a frequency change commits, and the outputs keep the old point throughout the sequence.
- R9: A mode write with the change bit, accepted while idle at clock edge E0, gives the following outputs. fc_start and pll_stop are high for the one cycle after E0. pll_restart is high for the one cycle after E0+1. lock_wait is high from E0+2 until the commit. busy is high from E0 until the commit.
- R10: During the wait, the first edge at which pll_lock is sampled high commits the staged ratios, clears busy and lock_wait, and updates the codes after that edge.
- R11: With pll_lock held low and timeout T, the commit happens at edge E0+3+T.
- R12: A change request written while busy is ignored, and its mode bits do not apply. req_dropped is high for the one cycle after that write.
- R13: A mode write without the change bit takes effect on the codes after its edge. It leaves pll_stop and busy at 0.
- R14: point_boot is 1 exactly while the committed run multiplier equals 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_wr | input | 1 | Write strobe for the staged ratio register |
| ratio_run | input | 5 | Run multiplier L |
| ratio_turbo | input | 3 | Turbo field N2 (twice the turbo ratio) |
| ratio_memsel | input | 1 | Memory clock follows bus clock when set |
| cfg_wr | input | 1 | Write strobe for the mode word |
| cfg_fast_bus | input | 1 | Bus at run frequency when set |
| cfg_change | input | 1 | Start a frequency change |
| cfg_turbo | input | 1 | Turbo enable |
| cfg_half | input | 1 | Half-turbo enable |
| cfg_osc | input | 1 | Run everything from the crystal |
| lock_timeout | input | 16 | Wait limit in cycles for PLL lock |
| pll_lock | input | 1 | Lock indication from the PLL |
| core_mhz | output | 12 | Core frequency code in MHz |
| bus_mhz | output | 12 | System-bus frequency code in MHz |
| mem_mhz | output | 12 | Memory-controller frequency code in MHz |
| pll_stop | output | 1 | PLL stop request |
| pll_restart | output | 1 | PLL restart pulse |
| lock_wait | output | 1 | Waiting for lock |
| busy | output | 1 | Frequency change in progress |
| fc_start | output | 1 | Frequency-change start pulse |
| req_dropped | output | 1 | Change request ignored while busy |
| point_boot | output | 1 | Committed point is the boot point |

## Verification
The bench builds the block with its defaults: 5-bit run field, 3-bit turbo field, 12-bit codes, 16-bit timeout and lock sensing enabled. The timeout is an input, so short values such as 0 and 5 let the bench reach both the lock exit and the timeout exit within a few cycles. The full field ranges let random ratios reach both sides of the memory split at 10 and the largest product, which has to fit in 12 bits.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE    = 2'd0,
      SQ_STOP    = 2'd1,
      SQ_RESTART = 2'd2,
      SQ_WAIT    = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic osc;
      logic half;
      logic turbo;
      logic fast;
   } clk_mode_t;

   localparam clk_mode_t MODE_RESET = '{osc: 1'b0, half: 1'b0, turbo: 1'b0, fast: 1'b0};

endpackage

// File: rtl/ccr_regs.sv
module ccr_regs
   import ccr_pkg::*;
#(
   parameter int RUN_W   = 5,
   parameter int TURBO_W = 3,
   parameter int BOOT_L  = 7,
   parameter int BOOT_N2 = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ratio_wr,
   input  logic [RUN_W-1:0]   ratio_run,
   input  logic [TURBO_W-1:0] ratio_turbo,
   input  logic               ratio_memsel,
   input  logic               mode_wr,
   input  clk_mode_t          mode_in,
   input  logic               commit,
   output logic [RUN_W-1:0]   run_q,
   output logic [TURBO_W-1:0] turbo_q,
   output logic               memsel_q,
   output clk_mode_t          mode_q
);

   logic [RUN_W-1:0]   run_stage;
   logic [TURBO_W-1:0] turbo_stage;
   logic               memsel_stage;

   // staged copy: written by software at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_stage    <= RUN_W'(BOOT_L);
         turbo_stage  <= TURBO_W'(BOOT_N2);
         memsel_stage <= 1'b0;
      end else if (ratio_wr) begin
         run_stage    <= ratio_run;
         turbo_stage  <= ratio_turbo;
         memsel_stage <= ratio_memsel;
      end
   end

   // committed copy: loaded only at the end of a change sequence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= RUN_W'(BOOT_L);
         turbo_q  <= TURBO_W'(BOOT_N2);
         memsel_q <= 1'b0;
      end else if (commit) begin
         run_q    <= run_stage;
         turbo_q  <= turbo_stage;
         memsel_q <= memsel_stage;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
      end else if (mode_wr) begin
         mode_q <= mode_in;
      end
   end

endmodule

// File: rtl/ccr_seq.sv
module ccr_seq
   import ccr_pkg::*;
#(
   parameter int DELAY_W  = 16,
   parameter bit USE_LOCK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic               pll_lock,
   input  logic [DELAY_W-1:0] lock_timeout,
   output logic               busy,
   output logic               fc_start,
   output logic               pll_stop,
   output logic               pll_restart,
   output logic               lock_wait,
   output logic               commit,
   output logic               req_dropped
);

   seq_state_t         state_q;
   seq_state_t         state_d;
   logic [DELAY_W-1:0] cnt_q;
   logic               lock_ok;
   logic               expired;

   generate
      if (USE_LOCK) begin : g_lock
         assign lock_ok = pll_lock;
      end else begin : g_nolock
         logic unused_lock;
         assign unused_lock = pll_lock;
         assign lock_ok     = 1'b0;
      end
   endgenerate

   assign expired = (cnt_q >= lock_timeout);
   assign commit  = (state_q == SQ_WAIT) && (lock_ok || expired);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE:    if (req) state_d = SQ_STOP;
         SQ_STOP:    state_d = SQ_RESTART;
         SQ_RESTART: state_d = SQ_WAIT;
         SQ_WAIT:    if (commit) state_d = SQ_IDLE;
         default:    state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         cnt_q       <= '0;
         fc_start    <= 1'b0;
         req_dropped <= 1'b0;
      end else begin
         state_q     <= state_d;
         fc_start    <= req && (state_q == SQ_IDLE);
         req_dropped <= req && (state_q != SQ_IDLE);
         if (state_q == SQ_RESTART) begin
            cnt_q <= '0;
         end else if (state_q == SQ_WAIT && !commit) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy        = (state_q != SQ_IDLE);
   assign pll_stop    = (state_q == SQ_STOP);
   assign pll_restart = (state_q == SQ_RESTART);
   assign lock_wait   = (state_q == SQ_WAIT);

endmodule

// File: rtl/ccr_freq.sv
module ccr_freq
   import ccr_pkg::*;
#(
   parameter int RUN_W     = 5,
   parameter int TURBO_W   = 3,
   parameter int FREQ_W    = 12,
   parameter int XTAL_MHZ  = 13,
   parameter int MEM_SPLIT = 10
) (
   input  logic [RUN_W-1:0]   run_q,
   input  logic [TURBO_W-1:0] turbo_q,
   input  logic               memsel_q,
   input  clk_mode_t          mode_q,
   output logic [FREQ_W-1:0]  core_mhz,
   output logic [FREQ_W-1:0]  bus_mhz,
   output logic [FREQ_W-1:0]  mem_mhz
);

   localparam int PW = FREQ_W + TURBO_W;

   logic [PW-1:0] run_f;
   logic [PW-1:0] prod_f;
   logic [PW-1:0] turbo_f;
   logic [PW-1:0] half_f;
   logic [PW-1:0] core_pll;
   logic [PW-1:0] bus_pll;
   logic [PW-1:0] mem_tab;
   logic [PW-1:0] mem_pll;

   assign run_f   = PW'(XTAL_MHZ) * PW'(run_q);
   assign prod_f  = run_f * PW'(turbo_q);
   assign turbo_f = prod_f >> 1;
   assign half_f  = prod_f >> 2;

   // half turbo outranks turbo
   always_comb begin
      if (mode_q.half)       core_pll = half_f;
      else if (mode_q.turbo) core_pll = turbo_f;
      else                   core_pll = run_f;
   end

   assign bus_pll = mode_q.fast ? run_f : (run_f >> 1);

   generate
      if (MEM_SPLIT > 0) begin : g_split
         assign mem_tab = (int'(run_q) <= MEM_SPLIT) ? run_f : (run_f >> 1);
      end else begin : g_half
         assign mem_tab = run_f >> 1;
      end
   endgenerate

   assign mem_pll = memsel_q ? bus_pll : mem_tab;

   // crystal bypass outranks every other setting
   assign core_mhz = mode_q.osc ? FREQ_W'(XTAL_MHZ) : FREQ_W'(core_pll);
   assign bus_mhz  = mode_q.osc ? FREQ_W'(XTAL_MHZ) : FREQ_W'(bus_pll);
   assign mem_mhz  = mode_q.osc ? FREQ_W'(XTAL_MHZ) : FREQ_W'(mem_pll);

endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
   import ccr_pkg::*;
#(
   parameter int RUN_W     = 5,
   parameter int TURBO_W   = 3,
   parameter int FREQ_W    = 12,
   parameter int DELAY_W   = 16,
   parameter int XTAL_MHZ  = 13,
   parameter int MEM_SPLIT = 10,
   parameter int BOOT_L    = 7,
   parameter int BOOT_N2   = 2,
   parameter bit USE_LOCK  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ratio_wr,
   input  logic [RUN_W-1:0]   ratio_run,
   input  logic [TURBO_W-1:0] ratio_turbo,
   input  logic               ratio_memsel,
   input  logic               cfg_wr,
   input  logic               cfg_fast_bus,
   input  logic               cfg_change,
   input  logic               cfg_turbo,
   input  logic               cfg_half,
   input  logic               cfg_osc,
   input  logic [DELAY_W-1:0] lock_timeout,
   input  logic               pll_lock,
   output logic [FREQ_W-1:0]  core_mhz,
   output logic [FREQ_W-1:0]  bus_mhz,
   output logic [FREQ_W-1:0]  mem_mhz,
   output logic               pll_stop,
   output logic               pll_restart,
   output logic               lock_wait,
   output logic               busy,
   output logic               fc_start,
   output logic               req_dropped,
   output logic               point_boot
);

   localparam longint MAX_RUN  = longint'(XTAL_MHZ) * ((longint'(1) << RUN_W) - 1);
   localparam longint MAX_PROD = MAX_RUN * ((longint'(1) << TURBO_W) - 1);

   generate
      if (RUN_W < 1 || TURBO_W < 1 || DELAY_W < 1) begin : g_bad_width
         $error("clk_ratio_ctrl: field widths must be positive");
      end
      if (MAX_PROD / 2 >= (longint'(1) << FREQ_W) || MAX_RUN >= (longint'(1) << FREQ_W)) begin : g_bad_freq
         $error("clk_ratio_ctrl: FREQ_W too narrow for the largest frequency");
      end
      if (BOOT_L >= (1 << RUN_W) || BOOT_N2 >= (1 << TURBO_W)) begin : g_bad_boot
         $error("clk_ratio_ctrl: boot point does not fit the ratio fields");
      end
   endgenerate

   logic               chg_req;
   logic               mode_wr;
   logic               commit;
   clk_mode_t          mode_in;
   clk_mode_t          mode_q;
   logic [RUN_W-1:0]   run_q;
   logic [TURBO_W-1:0] turbo_q;
   logic               memsel_q;

   assign chg_req = cfg_wr && cfg_change;
   // a change request while busy is dropped together with its mode bits
   assign mode_wr = cfg_wr && !(cfg_change && busy);
   assign mode_in = '{osc: cfg_osc, half: cfg_half, turbo: cfg_turbo, fast: cfg_fast_bus};

   ccr_regs #(
      .RUN_W   (RUN_W),
      .TURBO_W (TURBO_W),
      .BOOT_L  (BOOT_L),
      .BOOT_N2 (BOOT_N2)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .ratio_wr     (ratio_wr),
      .ratio_run    (ratio_run),
      .ratio_turbo  (ratio_turbo),
      .ratio_memsel (ratio_memsel),
      .mode_wr      (mode_wr),
      .mode_in      (mode_in),
      .commit       (commit),
      .run_q        (run_q),
      .turbo_q      (turbo_q),
      .memsel_q     (memsel_q),
      .mode_q       (mode_q)
   );

   ccr_seq #(
      .DELAY_W  (DELAY_W),
      .USE_LOCK (USE_LOCK)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (chg_req),
      .pll_lock     (pll_lock),
      .lock_timeout (lock_timeout),
      .busy         (busy),
      .fc_start     (fc_start),
      .pll_stop     (pll_stop),
      .pll_restart  (pll_restart),
      .lock_wait    (lock_wait),
      .commit       (commit),
      .req_dropped  (req_dropped)
   );

   ccr_freq #(
      .RUN_W     (RUN_W),
      .TURBO_W   (TURBO_W),
      .FREQ_W    (FREQ_W),
      .XTAL_MHZ  (XTAL_MHZ),
      .MEM_SPLIT (MEM_SPLIT)
   ) u_freq (
      .run_q    (run_q),
      .turbo_q  (turbo_q),
      .memsel_q (memsel_q),
      .mode_q   (mode_q),
      .core_mhz (core_mhz),
      .bus_mhz  (bus_mhz),
      .mem_mhz  (mem_mhz)
   );

   assign point_boot = (run_q == RUN_W'(BOOT_L));

endmodule

// File: rtl/ccr_chk.sv
module ccr_chk #(
   parameter int FREQ_W   = 12,
   parameter int XTAL_MHZ = 13,
   parameter bit USE_LOCK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fc_start,
   input logic              pll_stop,
   input logic              pll_restart,
   input logic              lock_wait,
   input logic              busy,
   input logic              req_dropped,
   input logic              pll_lock,
   input logic              osc_q,
   input logic [FREQ_W-1:0] core_mhz,
   input logic [FREQ_W-1:0] bus_mhz,
   input logic [FREQ_W-1:0] mem_mhz
);

   // R9: start pulse lasts one cycle
   a_r9_fc_single: assert property (@(posedge clk) disable iff (!rst_n)
      fc_start |=> !fc_start);

   // R9: stop is followed by restart, restart by the lock wait
   a_r9_stop_restart: assert property (@(posedge clk) disable iff (!rst_n)
      pll_stop |=> pll_restart);

   a_r9_restart_wait: assert property (@(posedge clk) disable iff (!rst_n)
      pll_restart |=> lock_wait);

   // R9: the three phase outputs never overlap
   a_r9_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pll_stop, pll_restart, lock_wait}));

   // R10: lock seen during the wait ends the change
   a_r10_lock_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_LOCK && lock_wait && pll_lock) |=> !busy);

   // R12: a drop flag only follows a busy cycle
   a_r12_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_dropped |-> $past(busy));

   // R7: crystal bypass forces every code to the crystal value
   a_r7_osc_codes: assert property (@(posedge clk) disable iff (!rst_n)
      osc_q |-> (core_mhz == FREQ_W'(XTAL_MHZ) && bus_mhz == FREQ_W'(XTAL_MHZ)
                 && mem_mhz == FREQ_W'(XTAL_MHZ)));

endmodule

bind clk_ratio_ctrl ccr_chk #(
   .FREQ_W   (FREQ_W),
   .XTAL_MHZ (XTAL_MHZ),
   .USE_LOCK (USE_LOCK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fc_start    (fc_start),
   .pll_stop    (pll_stop),
   .pll_restart (pll_restart),
   .lock_wait   (lock_wait),
   .busy        (busy),
   .req_dropped (req_dropped),
   .pll_lock    (pll_lock),
   .osc_q       (mode_q.osc),
   .core_mhz    (core_mhz),
   .bus_mhz     (bus_mhz),
   .mem_mhz     (mem_mhz)
);

// File: tb/tb_clk_ratio_ctrl.sv
`timescale 1ns/1ps
module tb_clk_ratio_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ratio_wr, ratio_memsel;
   logic [4:0]  ratio_run;
   logic [2:0]  ratio_turbo;
   logic        cfg_wr, cfg_fast_bus, cfg_change, cfg_turbo, cfg_half, cfg_osc;
   logic [15:0] lock_timeout;
   logic        pll_lock;
   logic [11:0] core_mhz, bus_mhz, mem_mhz;
   logic        pll_stop, pll_restart, lock_wait, busy, fc_start, req_dropped, point_boot;

   always #10 clk = ~clk;

   clk_ratio_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ratio_wr(ratio_wr), .ratio_run(ratio_run),
      .ratio_turbo(ratio_turbo), .ratio_memsel(ratio_memsel), .cfg_wr(cfg_wr),
      .cfg_fast_bus(cfg_fast_bus), .cfg_change(cfg_change), .cfg_turbo(cfg_turbo),
      .cfg_half(cfg_half), .cfg_osc(cfg_osc), .lock_timeout(lock_timeout),
      .pll_lock(pll_lock), .core_mhz(core_mhz), .bus_mhz(bus_mhz), .mem_mhz(mem_mhz),
      .pll_stop(pll_stop), .pll_restart(pll_restart), .lock_wait(lock_wait),
      .busy(busy), .fc_start(fc_start), .req_dropped(req_dropped), .point_boot(point_boot)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model
   int cL = 7, cN = 2, cMs = 0;
   int sL = 7, sN = 2, sMs = 0;
   int mFast = 0, mTurbo = 0, mHalf = 0, mOsc = 0;

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int f_run();   return 13 * cL; endfunction
   function automatic int f_core();
      if (mOsc != 0)   return 13;
      if (mHalf != 0)  return (13 * cL * cN) / 4;
      if (mTurbo != 0) return (13 * cL * cN) / 2;
      return f_run();
   endfunction
   function automatic int f_bus();
      if (mOsc != 0) return 13;
      return (mFast != 0) ? f_run() : f_run() / 2;
   endfunction
   function automatic int f_mem();
      if (mOsc != 0) return 13;
      if (cMs != 0)  return f_bus();
      return (cL <= 10) ? f_run() : f_run() / 2;
   endfunction

   function automatic string tag_for();
      if (mOsc != 0)   return "R7";
      if (mHalf != 0)  return "R4";
      if (mTurbo != 0) return "R3";
      return "R2";
   endfunction

   task automatic check_outs(string ctx);
      check({tag_for(), " core ", ctx}, int'(core_mhz), f_core());
      check({(mOsc != 0) ? "R7" : "R5", " bus ", ctx}, int'(bus_mhz), f_bus());
      check({(mOsc != 0) ? "R7" : "R6", " mem ", ctx}, int'(mem_mhz), f_mem());
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_ratio(int l, int n, int ms);
      ratio_run = 5'(l); ratio_turbo = 3'(n); ratio_memsel = ms[0]; ratio_wr = 1'b1;
      tick();
      ratio_wr = 1'b0;
      sL = l; sN = n; sMs = ms;
   endtask

   task automatic wr_cfg(int fast, int chg, int tb, int hf, int os, bit accepted);
      cfg_fast_bus = fast[0]; cfg_change = chg[0]; cfg_turbo = tb[0];
      cfg_half = hf[0]; cfg_osc = os[0]; cfg_wr = 1'b1;
      tick();
      cfg_wr = 1'b0; cfg_change = 1'b0;
      if (accepted) begin
         mFast = fast; mTurbo = tb; mHalf = hf; mOsc = os;
      end
   endtask

   // full change sequence; use_lock selects the lock exit or the timeout exit
   task automatic run_change(int fast, int tb, int hf, int os, bit use_lock, int t);
      lock_timeout = 16'(t);
      wr_cfg(fast, 1, tb, hf, os, 1'b1);
      check("R9 fc_start", int'(fc_start), 1);
      check("R9 pll_stop", int'(pll_stop), 1);
      check("R9 busy", int'(busy), 1);
      check_outs("R8 old point during stop");
      tick();
      check("R9 pll_restart", int'(pll_restart), 1);
      check("R9 fc_start low", int'(fc_start), 0);
      tick();
      check("R9 lock_wait", int'(lock_wait), 1);
      if (use_lock) begin
         pll_lock = 1'b1;
         tick();
         pll_lock = 1'b0;
         check("R10 busy cleared on lock", int'(busy), 0);
         check("R10 lock_wait cleared", int'(lock_wait), 0);
      end else begin
         repeat (t) tick();
         check("R11 busy before timeout", int'(busy), 1);
         check_outs("R8 old point in wait");
         tick();
         check("R11 busy cleared at timeout", int'(busy), 0);
      end
      cL = sL; cN = sN; cMs = sMs;
      check_outs("after commit");
      check("R14 point_boot", int'(point_boot), (cL == 7) ? 1 : 0);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd2024);
      rst_n = 1'b0; ratio_wr = 1'b0; ratio_run = '0; ratio_turbo = '0; ratio_memsel = 1'b0;
      cfg_wr = 1'b0; cfg_fast_bus = 1'b0; cfg_change = 1'b0; cfg_turbo = 1'b0;
      cfg_half = 1'b0; cfg_osc = 1'b0; lock_timeout = 16'd3; pll_lock = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset point
      check("R1 core", int'(core_mhz), 91);
      check("R1 bus", int'(bus_mhz), 45);
      check("R1 mem", int'(mem_mhz), 91);
      check("R1 point_boot", int'(point_boot), 1);
      check("R1 busy", int'(busy), 0);
      check("R1 pll outputs", int'({pll_stop, pll_restart, lock_wait, fc_start, req_dropped}), 0);

      // R8 ratio write alone leaves the outputs
      wr_ratio(16, 6, 0);
      tick(); tick();
      check_outs("R8 staged only");
      check("R8 point_boot kept", int'(point_boot), 1);

      // commit L=16 N2=6 through the lock exit
      run_change(1, 0, 0, 0, 1'b1, 100);
      check("R2 run 208", int'(core_mhz), 208);

      // R13 turbo without change: 624, no PLL activity
      wr_cfg(1, 0, 1, 0, 0, 1'b1);
      check("R13 pll_stop idle", int'(pll_stop), 0);
      check("R13 busy idle", int'(busy), 0);
      check("R3 turbo 624", int'(core_mhz), 624);
      // R4 half turbo with and without turbo
      wr_cfg(0, 0, 1, 1, 0, 1'b1);
      check("R4 half with turbo", int'(core_mhz), 312);
      check_outs("R4 bus slow");
      wr_cfg(0, 0, 0, 1, 0, 1'b1);
      check("R4 half without turbo", int'(core_mhz), 312);
      // R7 crystal bypass
      wr_cfg(1, 0, 1, 1, 1, 1'b1);
      check_outs("R7 bypass");

      // R11 timeout exit, T=5, and back to boot multiplier for R14
      wr_ratio(7, 2, 1);
      run_change(0, 0, 0, 0, 1'b0, 5);
      // timeout 0 edge case
      wr_ratio(12, 4, 0);
      run_change(1, 1, 0, 0, 1'b0, 0);
      check("R6 mem above split", int'(mem_mhz), 78);

      // R12 change request while busy is dropped
      wr_ratio(10, 3, 0);
      lock_timeout = 16'd4;
      wr_cfg(1, 1, 0, 0, 0, 1'b1);
      tick(); tick();
      wr_cfg(0, 1, 1, 1, 1, 1'b0);
      check("R12 req_dropped", int'(req_dropped), 1);
      check_outs("R12 modes ignored");
      tick();
      check("R12 drop pulse ends", int'(req_dropped), 0);
      for (int i = 0; i < 20 && busy; i++) tick();
      check("R12 single sequence done", int'(busy), 0);
      cL = sL; cN = sN; cMs = sMs;
      check_outs("R12 after commit");
      check("R12 mode still clear", int'(core_mhz), 130);

      // random points
      for (int i = 0; i < 40; i++) begin
         int l, n, ms, fb, tb, hf, os;
         l  = 2 + int'($urandom_range(29));
         n  = 1 + int'($urandom_range(6));
         ms = int'($urandom_range(1));
         fb = int'($urandom_range(1)); tb = int'($urandom_range(1));
         hf = int'($urandom_range(1)); os = ($urandom_range(7) == 0) ? 1 : 0;
         wr_ratio(l, n, ms);
         check_outs("R8 random staged");
         run_change(fb, tb, hf, os, ($urandom_range(1) == 1), int'($urandom_range(6)));
         fb = int'($urandom_range(1)); tb = int'($urandom_range(1));
         hf = int'($urandom_range(1));
         wr_cfg(fb, 0, tb, hf, 0, 1'b1);
         check("R13 random no stop", int'(pll_stop), 0);
         check_outs("R13 random mode");
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule